// File: doc/BRIEF.md
# Time-Aligned Pulse-Per-Second Generator

This block drives a clock-out pin from a running time-of-day input that counts seconds and nanoseconds. Software writes a target time, normally the next whole second, and sets the enable. The block loads that target as its first edge time. When the incoming time reaches or passes the edge time, the pin changes level and the edge time moves forward by one half-period. With the default half-period of half a second, the result is a 1 Hz square wave. Its rising edges land on whole seconds and its falling edges on half seconds.

The edges are not produced by a free-running divider. Every edge comes from a comparison against the running clock, so the output stays in phase with the time base. This holds even when the time base is stepped or slewed. Each level change can also raise a one-cycle interrupt pulse. Clearing the enable parks the pin low at once. Setting it again re-arms the block on whatever target is then programmed.

Top module: `pps_aligner`

## Requirements
- R1: After reset, `pinOut` and `irqPulse` are both low.
- R2: One cycle after `enable` rises, the block loads `{tgtSec, tgtNs}` as its edge time. After that, `pinOut` goes high at the first clock edge where the sampled `{timeSec, timeNs}` is greater than or equal to the edge time.
- R3: After each level change, the next edge time is the previous edge time plus the half-period. A `halfPeriodNs` of zero selects the default of 500,000,000 ns, so the output has a 1-second period.
- R4: When the nanoseconds sum reaches 1,000,000,000 or more, one billion is subtracted from it and the seconds field increments. `halfPeriodNs` must be below one billion.
- R5: The comparison is greater-or-equal. If the target already lies in the past when the block arms, the pin toggles at the first comparison after loading.
- R6: `irqPulse` is high for exactly the one cycle that follows each level change, provided `intEnable` was high at that clock edge. It stays low when `intEnable` is low.
- R7: While `enable` is low, `pinOut` is low in the same cycle, without waiting for a clock edge. No toggles and no interrupt pulses occur.
- R8: A new rising edge on `enable` re-arms the block on the currently programmed target and half-period. The edge time from before the disable is not used.
- R9: A non-zero `halfPeriodNs` sets the spacing between successive level changes, in nanoseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Arms the generator; low forces the pin low |
| intEnable | input | 1 | Allows an interrupt pulse on each level change |
| tgtSec | input | 32 | Target time, seconds part |
| tgtNs | input | 32 | Target time, nanoseconds part (below 1e9) |
| halfPeriodNs | input | 32 | Half-period in ns; 0 selects 500,000,000 |
| timeSec | input | 32 | Running time, seconds |
| timeNs | input | 32 | Running time, nanoseconds |
| pinOut | output | 1 | Square-wave clock-out pin |
| irqPulse | output | 1 | One-cycle pulse per level change |

## Verification
The main function is tried against four time-input patterns, and each one separates a different fault. The first is a steady advance with the default half-period, which exposes a wrong compare or a wrong default. The second is a 300 ms half-period, whose edges straddle a second boundary and so reveal a broken nanosecond carry. The third is a disable taken while the pin is high, followed by a re-enable on a fresh target; this catches a pin that is not forced low and an edge time that is reused. The fourth is a forward step of the time base past a target, which tells a greater-or-equal compare apart from an equality compare. Interrupt pulses are compared on every cycle, with the interrupt enable both set and cleared.

// File: rtl/pps_pkg.sv
package pps_pkg;

  // Strobes issued by the control to the edge datapath each cycle.
  typedef struct packed {
    logic load;     // copy the programmed target into the edge time
    logic advance;  // toggle the pin and step the edge time
    logic clear;    // force the pin low, cancel pending interrupt
  } ppsStrobes_t;

  typedef enum logic {
    PPS_IDLE  = 1'b0,
    PPS_ARMED = 1'b1
  } ppsState_t;

endpackage

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        reached,
  output ppsStrobes_t strobes
);

  ppsState_t state, stateNext;

  always_comb begin
    stateNext       = state;
    strobes.load    = 1'b0;
    strobes.advance = 1'b0;
    strobes.clear   = !enable;
    if (!enable) begin
      stateNext = PPS_IDLE;
    end else if (state == PPS_IDLE) begin
      strobes.load = 1'b1;
      stateNext    = PPS_ARMED;
    end else if (reached) begin
      strobes.advance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PPS_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/pps_edge_dp.sv
module pps_edge_dp
  import pps_pkg::*;
#(
  parameter int SEC_W        = 32,
  parameter int NS_W         = 32,
  parameter int HALF_DEFAULT = 500000000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ppsStrobes_t      strobes,
  input  logic             intEnable,
  input  logic [SEC_W-1:0] tgtSec,
  input  logic [NS_W-1:0]  tgtNs,
  input  logic [NS_W-1:0]  halfPeriodNs,
  input  logic [SEC_W-1:0] timeSec,
  input  logic [NS_W-1:0]  timeNs,
  output logic             reached,
  output logic             pinLevel,
  output logic             irqPulse
);

  localparam logic [NS_W:0]   BILLION  = (NS_W+1)'(1000000000);
  localparam logic [NS_W-1:0] HALF_DEF = NS_W'(HALF_DEFAULT);

  logic [SEC_W-1:0] edgeSec;
  logic [NS_W-1:0]  edgeNs;
  logic [NS_W-1:0]  halfEff;
  logic [NS_W:0]    nsSum;
  logic             nsWrap;
  logic [SEC_W-1:0] nextSec;
  logic [NS_W-1:0]  nextNs;

  // Greater-or-equal compare of running time against the edge time.
  always_comb begin
    if (timeSec != edgeSec) reached = (timeSec > edgeSec);
    else                    reached = (timeNs >= edgeNs);
  end

  // Next edge time with a single carry step at one billion.
  always_comb begin
    halfEff = (halfPeriodNs == '0) ? HALF_DEF : halfPeriodNs;
    nsSum   = {1'b0, edgeNs} + {1'b0, halfEff};
    nsWrap  = (nsSum >= BILLION);
    if (nsWrap) begin
      nextNs  = NS_W'(nsSum - BILLION);
      nextSec = edgeSec + SEC_W'(1);
    end else begin
      nextNs  = NS_W'(nsSum);
      nextSec = edgeSec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeSec  <= '0;
      edgeNs   <= '0;
      pinLevel <= 1'b0;
      irqPulse <= 1'b0;
    end else if (strobes.clear) begin
      pinLevel <= 1'b0;
      irqPulse <= 1'b0;
    end else if (strobes.load) begin
      edgeSec  <= tgtSec;
      edgeNs   <= tgtNs;
      irqPulse <= 1'b0;
    end else if (strobes.advance) begin
      edgeSec  <= nextSec;
      edgeNs   <= nextNs;
      pinLevel <= !pinLevel;
      irqPulse <= intEnable;
    end else begin
      irqPulse <= 1'b0;
    end
  end

endmodule

// File: rtl/pps_aligner.sv
module pps_aligner
  import pps_pkg::*;
#(
  parameter int SEC_W        = 32,
  parameter int NS_W         = 32,
  parameter int HALF_DEFAULT = 500000000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             intEnable,
  input  logic [SEC_W-1:0] tgtSec,
  input  logic [NS_W-1:0]  tgtNs,
  input  logic [NS_W-1:0]  halfPeriodNs,
  input  logic [SEC_W-1:0] timeSec,
  input  logic [NS_W-1:0]  timeNs,
  output logic             pinOut,
  output logic             irqPulse
);

  ppsStrobes_t strobes;
  logic        reached;
  logic        pinLevel;

  pps_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .reached (reached),
    .strobes (strobes)
  );

  pps_edge_dp #(
    .SEC_W        (SEC_W),
    .NS_W         (NS_W),
    .HALF_DEFAULT (HALF_DEFAULT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .intEnable    (intEnable),
    .tgtSec       (tgtSec),
    .tgtNs        (tgtNs),
    .halfPeriodNs (halfPeriodNs),
    .timeSec      (timeSec),
    .timeNs       (timeNs),
    .reached      (reached),
    .pinLevel     (pinLevel),
    .irqPulse     (irqPulse)
  );

  // Disable parks the pin low without waiting for a clock edge.
  assign pinOut = pinLevel & enable;

endmodule

// File: rtl/pps_aligner_chk.sv
module pps_aligner_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic intEnable,
  input logic irqPulse,
  input logic pinLevel
);

  // R6
  irq_marks_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (pinLevel != $past(pinLevel)));

  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |=> !irqPulse);

  // R7
  no_irq_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !irqPulse);

  // R7
  toggle_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinLevel != $past(pinLevel)) |-> ($past(enable) || !pinLevel));

endmodule

bind pps_aligner pps_aligner_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .intEnable (intEnable),
  .irqPulse  (irqPulse),
  .pinLevel  (pinLevel)
);

// File: tb/test_pps_aligner.sv
module test_pps_aligner;

  localparam longint BILLION = 64'd1000000000;
  localparam longint STEP    = 64'd20000000;

  typedef struct {
    longint t;
    logic   lvl;
    string  req;
  } expEdge_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        intEnable = 1'b0;
  logic [31:0] tgtSec = '0;
  logic [31:0] tgtNs = '0;
  logic [31:0] halfPeriodNs = '0;
  logic [31:0] timeSec = '0;
  logic [31:0] timeNs = '0;
  logic        pinOut;
  logic        irqPulse;

  int     compared = 0;
  int     mismatched = 0;
  longint nowNs = 0;
  logic   prevPin = 1'b0;
  logic   monOn = 1'b0;
  logic   done = 1'b0;
  expEdge_t expQ[$];

  always #2.5 clk = !clk;

  pps_aligner i_pps_aligner (
    .clk(clk), .rstN(rstN), .enable(enable), .intEnable(intEnable),
    .tgtSec(tgtSec), .tgtNs(tgtNs), .halfPeriodNs(halfPeriodNs),
    .timeSec(timeSec), .timeNs(timeNs), .pinOut(pinOut), .irqPulse(irqPulse)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic driveTime();
    timeSec = 32'(nowNs / BILLION);
    timeNs  = 32'(nowNs % BILLION);
  endtask

  // One cycle: time moves just after the falling edge.
  task automatic tick();
    @(negedge clk);
    #1;
    nowNs = nowNs + STEP;
    driveTime();
  endtask

  task automatic runUntil(input longint t);
    while (nowNs < t) tick();
  endtask

  task automatic pushEdge(input longint t, input logic lvl, input string req);
    expEdge_t e;
    e.t = t; e.lvl = lvl; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic setTarget(input longint t);
    tgtSec = 32'(t / BILLION);
    tgtNs  = 32'(t % BILLION);
  endtask

  // Monitor: pops an expected level change whenever the pin moves.
  always @(negedge clk) begin
    if (monOn) begin
      logic toggled;
      expEdge_t e;
      toggled = enable && (pinOut != prevPin);
      if (!enable) check(pinOut == 1'b0, "R7 pin low while disabled", pinOut, 0);
      if (toggled) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected toggle", nowNs, -1);
        end else begin
          e = expQ.pop_front();
          check(nowNs == e.t, {e.req, " edge time"}, nowNs, e.t);
          check(pinOut == e.lvl, {e.req, " edge level"}, pinOut, e.lvl);
        end
      end
      check(irqPulse == (toggled && intEnable), "R6 interrupt pulse", irqPulse,
            toggled && intEnable);
    end
    prevPin = pinOut;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    driveTime();
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(pinOut == 1'b0, "R1 reset pin", pinOut, 0);
    check(irqPulse == 1'b0, "R1 reset irq", irqPulse, 0);
    monOn = 1'b1;

    // R2 R3: default half-period, first edge on the 2 s target.
    setTarget(2 * BILLION);
    halfPeriodNs = '0;
    intEnable = 1'b1;
    pushEdge(64'd2000000000, 1'b1, "R2");
    pushEdge(64'd2500000000, 1'b0, "R3");
    pushEdge(64'd3000000000, 1'b1, "R3");
    pushEdge(64'd3500000000, 1'b0, "R3");
    pushEdge(64'd4000000000, 1'b1, "R3");
    enable = 1'b1;
    runUntil(64'd4100000000);
    check(expQ.size() == 0, "R3 all default edges seen", expQ.size(), 0);

    // R7: disable while high, pin drops in the same cycle.
    @(negedge clk);
    #1 enable = 1'b0;
    #1 check(pinOut == 1'b0, "R7 immediate low", pinOut, 0);
    runUntil(64'd5200000000);

    // R8 R9 R4: new target and 300 ms half-period, edges cross 7 s.
    setTarget(6 * BILLION);
    halfPeriodNs = 32'd300000000;
    intEnable = 1'b0;
    pushEdge(64'd6000000000, 1'b1, "R8");
    pushEdge(64'd6300000000, 1'b0, "R9");
    pushEdge(64'd6600000000, 1'b1, "R9");
    pushEdge(64'd6900000000, 1'b0, "R9");
    pushEdge(64'd7200000000, 1'b1, "R4");
    pushEdge(64'd7500000000, 1'b0, "R4");
    @(negedge clk);
    #1 enable = 1'b1;
    runUntil(64'd7600000000);
    check(expQ.size() == 0, "R4 all carried edges seen", expQ.size(), 0);

    // R5: time stepped forward past the target before arming.
    @(negedge clk);
    #1 enable = 1'b0;
    tick();
    nowNs = 20 * BILLION;
    driveTime();
    setTarget(64'd19900000000);
    halfPeriodNs = '0;
    intEnable = 1'b1;
    pushEdge(64'd20020000000, 1'b1, "R5");
    pushEdge(64'd20400000000, 1'b0, "R5");
    @(negedge clk);
    #1 enable = 1'b1;
    runUntil(64'd20500000000);
    check(expQ.size() == 0, "R5 past-target edges seen", expQ.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule